// File: doc/BRIEF.md
# Online-Alignment Multi-Term Floating-Point Adder

This block adds N_TERMS floating-point terms in a single parallel pass. Each term is given as an unsigned exponent and a two's complement significand. The significands are already unpacked. A balanced binary tree of one combining cell does the work. A cell takes two (exponent, significand) pairs and returns the larger exponent. It also returns the sum of both significands, each first shifted right by its distance from that larger exponent. Selecting the maximum exponent, computing the shift and adding all happen inside the same cell. No stage waits for a global maximum, so every subtree holds a valid partial result and the tree can be cut into pipeline stages at any level.

A register follows every tree level, so the block takes a new set of terms on every clock. A valid flag travels with the data. The output is the global maximum exponent and the aligned sum. The sum has the same width as one input significand, SIG_W bits including the sign, with no guard bits. This matches the format a conventional align-then-add adder would give to the normalization and rounding logic downstream. That logic is outside this block.

Top module: `fpa_online_adder`

## Requirements
- R1: Reset is synchronous and active low. After any rising clock edge at which rst_n is low, out_valid, out_exp and out_sig are all zero.
- R2: out_valid equals in_valid as it was LEVELS = log2(N_TERMS) rising edges earlier. At the defaults this is 5 edges.
- R3: When out_valid is high, out_exp equals the largest unsigned in_exp among the terms of the sample presented LEVELS edges earlier.
- R4: Term i occupies in_exp[i*EXP_W +: EXP_W] and in_sig[i*SIG_W +: SIG_W], and its significand is two's complement. out_sig is the result of a pairwise tree. The first level pairs terms 2j and 2j+1. Each later level pairs results 2j and 2j+1 of the level below. Each pair gives the larger exponent and the sum of both significands, each shifted arithmetically right by (larger exponent minus its own exponent). Shifted-out bits are dropped, and the sum is kept modulo 2^SIG_W.
- R5: When all exponents of a sample are equal, out_sig is the plain two's complement sum of all significands modulo 2^SIG_W.
- R6: A shift distance of SIG_W-1 or more saturates instead of wrapping. The aligned significand becomes 0 for a non-negative value and -1 for a negative value.
- R7: When every significand of a sample is zero, out_sig is zero, and out_exp is still the maximum exponent of that sample.
- R8: A new sample may be presented on every cycle. Consecutive samples produce their own results on consecutive cycles, with no interference between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks the current set of terms as valid |
| in_exp | input | N_TERMS*EXP_W | Packed term exponents, unsigned, term i at bit i*EXP_W |
| in_sig | input | N_TERMS*SIG_W | Packed term significands, two's complement, term i at bit i*SIG_W |
| out_valid | output | 1 | Result valid |
| out_exp | output | EXP_W | Maximum exponent of the sample |
| out_sig | output | SIG_W | Aligned sum at the maximum exponent |

## Verification
Each result is due exactly LEVELS rising edges after the sample is presented. Inputs are changed on the falling edge, so a sample applied before edge p appears on the outputs just after edge p+LEVELS-1. The bench pushes one expected entry per driven cycle into a queue. It pops the front entry only once the queue holds LEVELS entries, at the falling edge before it drives the next sample. Each popped entry is therefore compared with the output that belongs to it. The valid flag is compared on every cycle. Exponent and significand are compared whenever a valid result is due.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    // Default geometry: 32 terms, 8-bit exponent, 9-bit signed significand.
    localparam int DEF_TERMS = 32;
    localparam int DEF_EXP_W = 8;
    localparam int DEF_SIG_W = 9;
endpackage

// File: rtl/fpa_align_cell.sv
// Combining cell: larger exponent, plus the sum of both aligned significands.
module fpa_align_cell #(
    parameter int EXP_W = fpa_pkg::DEF_EXP_W,
    parameter int SIG_W = fpa_pkg::DEF_SIG_W
) (
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    output logic [EXP_W-1:0] y_exp,
    output logic [SIG_W-1:0] y_sig
);
    localparam int SH_W   = $clog2(SIG_W);
    localparam int SH_MAX = SIG_W - 1;

    logic [EXP_W-1:0]        big_exp;
    logic [EXP_W-1:0]        dist_a;
    logic [EXP_W-1:0]        dist_b;
    logic [SH_W-1:0]         sh_a;
    logic [SH_W-1:0]         sh_b;
    logic signed [SIG_W-1:0] al_a;
    logic signed [SIG_W-1:0] al_b;

    always_comb begin
        big_exp = (a_exp >= b_exp) ? a_exp : b_exp;
        dist_a  = big_exp - a_exp;
        dist_b  = big_exp - b_exp;
        // Saturate the distance: a shift by SIG_W-1 already gives pure sign fill.
        sh_a    = (dist_a >= EXP_W'(SH_MAX)) ? SH_W'(SH_MAX) : dist_a[SH_W-1:0];
        sh_b    = (dist_b >= EXP_W'(SH_MAX)) ? SH_W'(SH_MAX) : dist_b[SH_W-1:0];
        al_a    = $signed(a_sig) >>> sh_a;
        al_b    = $signed(b_sig) >>> sh_b;
        y_exp   = big_exp;
        y_sig   = al_a + al_b;
    end
endmodule

// File: rtl/fpa_tree_stage.sv
// One tree level: IN_TERMS/2 combining cells followed by a register.
module fpa_tree_stage #(
    parameter int EXP_W    = fpa_pkg::DEF_EXP_W,
    parameter int SIG_W    = fpa_pkg::DEF_SIG_W,
    parameter int IN_TERMS = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [IN_TERMS*EXP_W-1:0]         in_exp,
    input  logic [IN_TERMS*SIG_W-1:0]         in_sig,
    output logic                              out_valid,
    output logic [(IN_TERMS/2)*EXP_W-1:0]     out_exp,
    output logic [(IN_TERMS/2)*SIG_W-1:0]     out_sig
);
    localparam int OUT_TERMS = IN_TERMS / 2;

    typedef struct packed {
        logic                         vld;
        logic [OUT_TERMS*EXP_W-1:0]   exp;
        logic [OUT_TERMS*SIG_W-1:0]   sig;
    } stage_t;

    stage_t                     st_d;
    stage_t                     st_q;
    logic [OUT_TERMS*EXP_W-1:0] cell_exp;
    logic [OUT_TERMS*SIG_W-1:0] cell_sig;

    for (genvar g = 0; g < OUT_TERMS; g++) begin : g_cell
        fpa_align_cell #(
            .EXP_W (EXP_W),
            .SIG_W (SIG_W)
        ) u_cell (
            .a_exp (in_exp[(2*g)*EXP_W +: EXP_W]),
            .a_sig (in_sig[(2*g)*SIG_W +: SIG_W]),
            .b_exp (in_exp[(2*g+1)*EXP_W +: EXP_W]),
            .b_sig (in_sig[(2*g+1)*SIG_W +: SIG_W]),
            .y_exp (cell_exp[g*EXP_W +: EXP_W]),
            .y_sig (cell_sig[g*SIG_W +: SIG_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.exp = cell_exp;
        st_d.sig = cell_sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_exp   = st_q.exp;
    assign out_sig   = st_q.sig;
endmodule

// File: rtl/fpa_online_adder.sv
// Balanced, fully pipelined tree of combining cells over N_TERMS inputs.
module fpa_online_adder #(
    parameter int N_TERMS = fpa_pkg::DEF_TERMS,
    parameter int EXP_W   = fpa_pkg::DEF_EXP_W,
    parameter int SIG_W   = fpa_pkg::DEF_SIG_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [N_TERMS*EXP_W-1:0]   in_exp,
    input  logic [N_TERMS*SIG_W-1:0]   in_sig,
    output logic                       out_valid,
    output logic [EXP_W-1:0]           out_exp,
    output logic [SIG_W-1:0]           out_sig
);
    localparam int LEVELS = $clog2(N_TERMS);
    localparam int NODES  = 2 * N_TERMS - 1;

    // Heap-style node store: level k starts at node 2*N - 2*(N >> k).
    logic [NODES*EXP_W-1:0] node_exp;
    logic [NODES*SIG_W-1:0] node_sig;
    logic [LEVELS:0]        node_vld;

    assign node_exp[N_TERMS*EXP_W-1:0] = in_exp;
    assign node_sig[N_TERMS*SIG_W-1:0] = in_sig;
    assign node_vld[0]                 = in_valid;

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        localparam int IN_T    = N_TERMS >> k;
        localparam int IN_OFF  = 2 * N_TERMS - 2 * IN_T;
        localparam int OUT_OFF = 2 * N_TERMS - IN_T;

        fpa_tree_stage #(
            .EXP_W    (EXP_W),
            .SIG_W    (SIG_W),
            .IN_TERMS (IN_T)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (node_vld[k]),
            .in_exp    (node_exp[IN_OFF*EXP_W +: IN_T*EXP_W]),
            .in_sig    (node_sig[IN_OFF*SIG_W +: IN_T*SIG_W]),
            .out_valid (node_vld[k+1]),
            .out_exp   (node_exp[OUT_OFF*EXP_W +: (IN_T/2)*EXP_W]),
            .out_sig   (node_sig[OUT_OFF*SIG_W +: (IN_T/2)*SIG_W])
        );
    end

    assign out_valid = node_vld[LEVELS];
    assign out_exp   = node_exp[(NODES-1)*EXP_W +: EXP_W];
    assign out_sig   = node_sig[(NODES-1)*SIG_W +: SIG_W];
endmodule

// File: rtl/fpa_online_adder_chk.sv
// Checker: a flat (non-tree) view of each sample, delayed by the pipeline depth.
module fpa_online_adder_chk #(
    parameter int N_TERMS = fpa_pkg::DEF_TERMS,
    parameter int EXP_W   = fpa_pkg::DEF_EXP_W,
    parameter int SIG_W   = fpa_pkg::DEF_SIG_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [N_TERMS*EXP_W-1:0] in_exp,
    input logic [N_TERMS*SIG_W-1:0] in_sig,
    input logic                     out_valid,
    input logic [EXP_W-1:0]         out_exp,
    input logic [SIG_W-1:0]         out_sig
);
    localparam int L = $clog2(N_TERMS);

    logic [EXP_W-1:0] mx_now;
    logic [SIG_W-1:0] sum_now;
    logic             eq_now;
    logic             zero_now;

    logic [EXP_W-1:0] mx_h  [L];
    logic [SIG_W-1:0] sum_h [L];
    logic [L-1:0]     vld_h;
    logic [L-1:0]     eq_h;
    logic [L-1:0]     zero_h;

    always_comb begin
        mx_now   = in_exp[EXP_W-1:0];
        sum_now  = '0;
        eq_now   = 1'b1;
        zero_now = 1'b1;
        for (int i = 0; i < N_TERMS; i++) begin
            if (in_exp[i*EXP_W +: EXP_W] > mx_now) mx_now = in_exp[i*EXP_W +: EXP_W];
            if (in_exp[i*EXP_W +: EXP_W] != in_exp[EXP_W-1:0]) eq_now = 1'b0;
            if (in_sig[i*SIG_W +: SIG_W] != '0) zero_now = 1'b0;
            sum_now = sum_now + in_sig[i*SIG_W +: SIG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_h  <= '0;
            eq_h   <= '0;
            zero_h <= '0;
            for (int i = 0; i < L; i++) begin
                mx_h[i]  <= '0;
                sum_h[i] <= '0;
            end
        end else begin
            vld_h[0]  <= in_valid;
            eq_h[0]   <= eq_now;
            zero_h[0] <= zero_now;
            mx_h[0]   <= mx_now;
            sum_h[0]  <= sum_now;
            for (int i = 1; i < L; i++) begin
                vld_h[i]  <= vld_h[i-1];
                eq_h[i]   <= eq_h[i-1];
                zero_h[i] <= zero_h[i-1];
                mx_h[i]   <= mx_h[i-1];
                sum_h[i]  <= sum_h[i-1];
            end
        end
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_exp == '0 && out_sig == '0));

    // R2
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_h[L-1]);

    // R3
    a_r3_max_exponent: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_exp == mx_h[L-1]);

    // R5
    a_r5_equal_exp_plain_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && eq_h[L-1]) |-> out_sig == sum_h[L-1]);

    // R7
    a_r7_zero_terms: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zero_h[L-1]) |-> out_sig == '0);
endmodule

bind fpa_online_adder fpa_online_adder_chk #(
    .N_TERMS (N_TERMS),
    .EXP_W   (EXP_W),
    .SIG_W   (SIG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_exp    (in_exp),
    .in_sig    (in_sig),
    .out_valid (out_valid),
    .out_exp   (out_exp),
    .out_sig   (out_sig)
);

// File: tb/fpa_online_adder_test.sv
module fpa_online_adder_test;
    localparam int N  = 32;
    localparam int EW = 8;
    localparam int SW = 9;
    localparam int L  = 5;

    typedef struct {
        bit    vld;
        int    ex;
        int    sg;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [N*EW-1:0]   in_exp = '0;
    logic [N*SW-1:0]   in_sig = '0;
    logic              out_valid;
    logic [EW-1:0]     out_exp;
    logic [SW-1:0]     out_sig;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t q[$];
    int   te [N];
    int   ts [N];

    always #10 clk = ~clk;

    fpa_online_adder #(.N_TERMS(N), .EXP_W(EW), .SIG_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_exp(in_exp),
        .in_sig(in_sig), .out_valid(out_valid), .out_exp(out_exp), .out_sig(out_sig)
    );

    function automatic int wrap(input int x);
        int m = x & ((1 << SW) - 1);
        if (m >= (1 << (SW - 1))) m -= (1 << SW);
        return m;
    endfunction

    // Pairwise reduction with per-pair truncation, as stated in R4 and R6.
    function automatic void model(input int e[N], input int s[N], output int re, output int rs);
        int ce[N];
        int cs[N];
        ce = e;
        cs = s;
        for (int w = N; w > 1; w = w / 2) begin
            for (int i = 0; i < w / 2; i++) begin
                int m  = (ce[2*i] >= ce[2*i+1]) ? ce[2*i] : ce[2*i+1];
                int da = m - ce[2*i];
                int db = m - ce[2*i+1];
                if (da > 30) da = 30;
                if (db > 30) db = 30;
                cs[i] = wrap((cs[2*i] >>> da) + (cs[2*i+1] >>> db));
                ce[i] = m;
            end
        end
        re = ce[0];
        rs = cs[0];
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic compare_front();
        exp_t e;
        if (q.size() < L) return;
        e = q.pop_front();
        check({e.tag, "/R2 valid"}, int'(out_valid), int'(e.vld));
        if (e.vld) begin
            check({e.tag, "/R3 exponent"}, int'(out_exp), e.ex);
            check({e.tag, "/R4 significand"}, int'($signed(out_sig)), e.sg);
        end
    endtask

    task automatic present(input bit v, input string tag);
        exp_t e;
        int re, rs;
        for (int i = 0; i < N; i++) begin
            in_exp[i*EW +: EW] = EW'(te[i]);
            in_sig[i*SW +: SW] = SW'(ts[i]);
        end
        in_valid = v;
        model(te, ts, re, rs);
        e.vld = v;
        e.ex  = re;
        e.sg  = rs;
        e.tag = tag;
        q.push_back(e);
    endtask

    function automatic int rsig();
        return wrap(int'($urandom_range(0, (1 << SW) - 1)));
    endfunction

    // mode: 0 random, 1 equal exps, 2 wide gaps, 3 single nonzero, 4 all zero, 5 extremes
    task automatic step(input int mode, input bit v, input string tag);
        int pick = $urandom_range(0, N - 1);
        int eqe  = $urandom_range(0, 255);
        @(negedge clk);
        compare_front();
        for (int i = 0; i < N; i++) begin
            case (mode)
                0: begin te[i] = $urandom_range(0, 24);  ts[i] = rsig(); end
                1: begin te[i] = eqe;                    ts[i] = rsig(); end
                2: begin te[i] = $urandom_range(0, 255); ts[i] = rsig(); end
                3: begin te[i] = $urandom_range(0, 40);  ts[i] = (i == pick) ? rsig() : 0; end
                4: begin te[i] = $urandom_range(0, 255); ts[i] = 0; end
                default: begin
                    te[i] = ($urandom_range(0, 1) != 0) ? 255 : 0;
                    case ($urandom_range(0, 3))
                        0: ts[i] = -(1 << (SW - 1));
                        1: ts[i] = (1 << (SW - 1)) - 1;
                        2: ts[i] = -1;
                        default: ts[i] = 1;
                    endcase
                end
            endcase
        end
        present(v, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: outputs cleared while reset is applied, even with valid driven high.
        in_valid = 1'b1;
        in_sig   = '1;
        in_exp   = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset exponent", int'(out_exp), 0);
        check("R1 reset significand", int'(out_sig), 0);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // R6 directed: exp 20 sig -3 paired with exp 0 sig -100 saturates to -1; sum -4.
        @(negedge clk);
        for (int i = 0; i < N; i++) begin te[i] = 0; ts[i] = 0; end
        te[0] = 20; ts[0] = -3; te[1] = 0; ts[1] = -100;
        present(1'b1, "R6 directed");
        @(negedge clk);
        compare_front();
        // R4 directed: exp 5 sig 64 with exp 3 sig 64 gives 64 + 16 = 80 at exp 5.
        for (int i = 0; i < N; i++) begin te[i] = 0; ts[i] = 0; end
        te[0] = 5; ts[0] = 64; te[1] = 3; ts[1] = 64;
        present(1'b1, "R4 directed");

        for (int c = 0; c < 400; c++) step(0, $urandom_range(0, 3) != 0, "R4 random");
        for (int c = 0; c < 60; c++)  step(1, 1'b1, "R5 equal exponents");
        for (int c = 0; c < 60; c++)  step(2, 1'b1, "R6 wide gaps");
        for (int c = 0; c < 40; c++)  step(3, 1'b1, "R4 single term");
        for (int c = 0; c < 20; c++)  step(4, 1'b1, "R7 zero significands");
        for (int c = 0; c < 60; c++)  step(5, 1'b1, "R6 extremes");
        for (int c = 0; c < 100; c++) step(c % 6, 1'b1, "R8 back to back");
        for (int c = 0; c < 40; c++)  step(0, c[0], "R2 valid gaps");
        for (int c = 0; c < L + 1; c++) step(0, 1'b0, "R2 drain");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule